// File: doc/BRIEF.md
# Single-wire bus byte transfer engine with one-shot strong pullup

This block turns byte-level commands into a run of eight bit-slot requests for a lower slot-timing engine on a single-wire open-drain bus. A command picks one of three operations: write a byte, read a byte, or touch a byte. Touch drives each data bit and keeps whatever level the bus returned in that slot. The block walks the slots from the least significant bit upward. It gathers the returned levels into a result byte and reports completion with a one-cycle done pulse.

Some bus devices draw power for a conversion or a memory write right after a command byte. For them, the host can arm a one-shot hold duration in milliseconds. The next write or touch byte then ends with a hold phase. If strong pullup is enabled, the pullup enable output is driven for that many milliseconds. If it is not enabled, the block waits out the same time with the output low. The armed duration is consumed by that byte, so it applies to one byte only. Milliseconds are counted on the same microsecond tick that paces the slot engine.

Top module: `owb_byte_xfer`

## Requirements
- R1: After reset, busy, done, slot_req and spu_on are low and result is 0x00.
- R2: For write (cmd_op 0) and touch (cmd_op 2, with 3 treated as 2), slot i carries bit i of cmd_data. Bit 0 goes first.
- R3: A read (cmd_op 1) issues eight slots that all carry slot_bit 1. Bit i of result is the slot_rbit returned in slot i.
- R4: A touch sets bit i of result to the level returned in slot i. A write leaves result unchanged.
- R5: done is a single-cycle pulse in the first cycle that busy is low, and result takes its new value in that same cycle. A cmd_valid that arrives while busy is ignored.
- R6: A write or touch that starts with a nonzero armed duration N and pullup_en high raises spu_on in the cycle after the eighth slot_ack. spu_on stays high for exactly N×TICKS_PER_MS us_tick pulses, and done follows.
- R7: With a nonzero armed duration and pullup_en low, the byte waits the same N×TICKS_PER_MS ticks after its eighth slot before done, and spu_on stays low.
- R8: The armed duration is consumed by the write or touch byte that starts with it. The following byte has no hold phase.
- R9: Arming a duration of zero cancels a request armed earlier.
- R10: A request armed while a byte is in progress has no effect on that byte and applies to the next write or touch byte.
- R11: A read byte neither consumes the armed request nor raises spu_on.
- R12: spu_on is never high while slot_req is high, and slot_req is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond, shared with the slot engine |
| pullup_en | input | 1 | Strong pullup available; sampled when a byte starts |
| arm_valid | input | 1 | Load arm_ms as the one-shot hold request |
| arm_ms | input | MS_W | Hold duration in milliseconds; zero cancels |
| cmd_valid | input | 1 | Start a byte operation (taken only when idle) |
| cmd_op | input | 2 | 0 write, 1 read, 2 or 3 touch |
| cmd_data | input | DATA_W | Byte to send |
| busy | output | 1 | Byte operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Assembled read or touch byte |
| slot_req | output | 1 | Request one bit slot; held until slot_ack |
| slot_bit | output | 1 | Level to drive in the requested slot |
| slot_ack | input | 1 | Slot engine finished the slot (one-cycle pulse) |
| slot_rbit | input | 1 | Bus level sampled in that slot, valid with slot_ack |
| spu_on | output | 1 | Strong pullup enable |

## Verification
The bound checker watches on every cycle that the pullup never overlaps a slot request and that slot requests only happen while busy. It also checks that the slot level stays steady until it is acknowledged, that done is a lone pulse with busy low, and that result moves only with done. Bit ordering and byte assembly are covered by sweeping all 256 byte values through write, read and touch. Hold length in ticks, the one-shot consumption, cancellation, arming during a byte, and a read leaving the request intact are sequence properties. Only the bench scenarios show them.

// File: rtl/owb_byte_pkg.sv
`timescale 1ns/1ps
package owb_byte_pkg;

   typedef enum logic [1:0] {
      OP_WRITE     = 2'd0,
      OP_READ      = 2'd1,
      OP_TOUCH     = 2'd2,
      OP_TOUCH_ALT = 2'd3
   } owb_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SLOT = 2'd1,
      ST_HOLD = 2'd2
   } owb_st_e;

endpackage

// File: rtl/owb_pullup_arm.sv
`timescale 1ns/1ps
module owb_pullup_arm #(
   parameter int MS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm_valid,
   input  logic [MS_W-1:0] arm_ms,
   input  logic            consume,
   output logic [MS_W-1:0] armed_ms
);

   // a fresh arm wins over consumption in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_ms <= '0;
      end else if (arm_valid) begin
         armed_ms <= arm_ms;
      end else if (consume) begin
         armed_ms <= '0;
      end
   end

endmodule

// File: rtl/owb_slot_seq.sv
`timescale 1ns/1ps
module owb_slot_seq #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              read_mode,
   input  logic [DATA_W-1:0] data,
   input  logic              slot_ack,
   input  logic              slot_rbit,
   output logic              slot_req,
   output logic              slot_bit,
   output logic              last_done,
   output logic [DATA_W-1:0] cap_nxt,
   output logic [DATA_W-1:0] cap
);

   localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

   logic              active;
   logic              rd_q;
   logic [IW-1:0]     idx;
   logic [DATA_W-1:0] shreg;
   logic              step;

   assign step      = active && slot_ack;
   assign last_done = step && (idx == LAST_IDX);
   assign slot_req  = active;
   assign slot_bit  = rd_q ? 1'b1 : shreg[0];

   generate
      if (DATA_W > 1) begin : g_wide
         assign cap_nxt = {slot_rbit, cap[DATA_W-1:1]};
      end else begin : g_one
         assign cap_nxt = slot_rbit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         rd_q   <= 1'b0;
         idx    <= '0;
         shreg  <= '0;
         cap    <= '0;
      end else if (start) begin
         active <= 1'b1;
         rd_q   <= read_mode;
         idx    <= '0;
         shreg  <= data;
      end else if (step) begin
         shreg <= shreg >> 1;
         cap   <= cap_nxt;
         idx   <= idx + 1'b1;
         if (idx == LAST_IDX) begin
            active <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/owb_hold_timer.sv
`timescale 1ns/1ps
module owb_hold_timer #(
   parameter int MS_W         = 8,
   parameter int TICKS_PER_MS = 1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [MS_W-1:0] ms,
   input  logic            run,
   input  logic            us_tick,
   output logic            expire
);

   logic [MS_W-1:0] ms_left;
   logic            ms_wrap;

   generate
      if (TICKS_PER_MS > 1) begin : g_div
         localparam int TW = $clog2(TICKS_PER_MS);
         localparam logic [TW-1:0] TMAX = TW'(TICKS_PER_MS - 1);
         logic [TW-1:0] tcnt;
         assign ms_wrap = run && us_tick && (tcnt == TMAX);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tcnt <= '0;
            end else if (load) begin
               tcnt <= '0;
            end else if (run && us_tick) begin
               tcnt <= ms_wrap ? '0 : tcnt + 1'b1;
            end
         end
      end else begin : g_direct
         assign ms_wrap = run && us_tick;
      end
   endgenerate

   assign expire = ms_wrap && (ms_left == MS_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_left <= '0;
      end else if (load) begin
         ms_left <= ms;
      end else if (ms_wrap) begin
         ms_left <= ms_left - 1'b1;
      end
   end

endmodule

// File: rtl/owb_byte_xfer.sv
`timescale 1ns/1ps
module owb_byte_xfer
   import owb_byte_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int MS_W         = 8,
   parameter int TICKS_PER_MS = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              pullup_en,
   input  logic              arm_valid,
   input  logic [MS_W-1:0]   arm_ms,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              slot_req,
   output logic              slot_bit,
   input  logic              slot_ack,
   input  logic              slot_rbit,
   output logic              spu_on
);

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (MS_W < 1) begin : g_bad_ms
      $error("MS_W must be at least 1");
   end
   if (TICKS_PER_MS < 1) begin : g_bad_tick
      $error("TICKS_PER_MS must be at least 1");
   end

   owb_st_e           st;
   owb_op_e           op_q;
   logic [MS_W-1:0]   hold_q;
   logic              en_q;
   logic [MS_W-1:0]   armed_ms;
   logic              start;
   logic              consume;
   logic              last_done;
   logic              expire;
   logic              hold_load;
   logic [DATA_W-1:0] cap;
   logic [DATA_W-1:0] cap_nxt;

   assign start     = (st == ST_IDLE) && cmd_valid;
   assign consume   = start && (owb_op_e'(cmd_op) != OP_READ);
   assign hold_load = (st == ST_SLOT) && last_done && (hold_q != '0);
   assign busy      = (st != ST_IDLE);
   assign spu_on    = (st == ST_HOLD) && en_q;

   owb_pullup_arm #(.MS_W(MS_W)) u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_valid(arm_valid),
      .arm_ms   (arm_ms),
      .consume  (consume),
      .armed_ms (armed_ms)
   );

   owb_slot_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .read_mode(owb_op_e'(cmd_op) == OP_READ),
      .data     (cmd_data),
      .slot_ack (slot_ack),
      .slot_rbit(slot_rbit),
      .slot_req (slot_req),
      .slot_bit (slot_bit),
      .last_done(last_done),
      .cap_nxt  (cap_nxt),
      .cap      (cap)
   );

   owb_hold_timer #(.MS_W(MS_W), .TICKS_PER_MS(TICKS_PER_MS)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (hold_load),
      .ms     (hold_q),
      .run    (st == ST_HOLD),
      .us_tick(us_tick),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         op_q   <= OP_WRITE;
         hold_q <= '0;
         en_q   <= 1'b0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  op_q   <= owb_op_e'(cmd_op);
                  hold_q <= consume ? armed_ms : '0;
                  en_q   <= pullup_en;
                  st     <= ST_SLOT;
               end
            end
            ST_SLOT: begin
               if (last_done) begin
                  if (hold_q != '0) begin
                     st <= ST_HOLD;
                  end else begin
                     st   <= ST_IDLE;
                     done <= 1'b1;
                     if (op_q != OP_WRITE) result <= cap_nxt;
                  end
               end
            end
            ST_HOLD: begin
               if (expire) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
                  if (op_q != OP_WRITE) result <= cap;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/owb_byte_xfer_chk.sv
`timescale 1ns/1ps
module owb_byte_xfer_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] result,
   input logic              slot_req,
   input logic              slot_bit,
   input logic              slot_ack,
   input logic              spu_on
);

   // R12
   spu_slot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spu_on |-> !slot_req);

   // R12
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_req |-> busy);

   // R6
   spu_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spu_on |-> busy);

   // R2
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && !slot_ack) |=> (slot_req && $stable(slot_bit)));

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

endmodule

bind owb_byte_xfer owb_byte_xfer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/owb_byte_xfer_tb.sv
`timescale 1ns/1ps
module owb_byte_xfer_tb;

   localparam int TPM = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       us_tick = 1'b0;
   logic       pullup_en = 1'b0;
   logic       arm_valid = 1'b0;
   logic [7:0] arm_ms = '0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = '0;
   logic [7:0] cmd_data = '0;
   logic       busy, done, slot_req, slot_bit, spu_on;
   logic [7:0] result;
   logic       slot_ack = 1'b0;
   logic       slot_rbit = 1'b0;

   int checks = 0;
   int errors = 0;

   // slot responder state
   int         sidx = 0;
   int         wait_cnt = 0;
   logic [7:0] sent = '0;
   logic [7:0] resp = '0;
   logic       slots_done = 1'b0;

   // per-byte measurements
   int post_ticks, spu_ticks, overlap, dones;
   logic [7:0] exp_res = 8'h00;

   owb_byte_xfer #(.DATA_W(8), .MS_W(8), .TICKS_PER_MS(TPM)) u_dut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pullup_en(pullup_en),
      .arm_valid(arm_valid), .arm_ms(arm_ms), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy), .done(done),
      .result(result), .slot_req(slot_req), .slot_bit(slot_bit),
      .slot_ack(slot_ack), .slot_rbit(slot_rbit), .spu_on(spu_on)
   );

   always #2 clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // watchdog
   initial begin
      repeat (180000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // microsecond tick every third cycle
   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc = (tc + 1) % 3;
         us_tick = (tc == 0);
      end
   end

   // slot engine model: one-cycle ack after a short wait
   initial begin
      forever begin
         @(negedge clk);
         if (slot_ack) begin
            slot_ack = 1'b0;
            if (sidx == 8) slots_done = 1'b1;
         end else if (slot_req) begin
            if (wait_cnt < 1) begin
               wait_cnt++;
            end else begin
               wait_cnt = 0;
               if (sidx < 8) begin
                  sent[sidx] = slot_bit;
                  slot_rbit  = resp[sidx];
               end
               slot_ack = 1'b1;
               sidx++;
            end
         end
      end
   end

   task automatic arm(input int ms);
      @(negedge clk);
      arm_valid = 1'b1;
      arm_ms    = 8'(ms);
      @(negedge clk);
      arm_valid = 1'b0;
   endtask

   task automatic run_byte(input logic [1:0] op, input logic [7:0] data,
                           input logic [7:0] rv, input int mid_arm);
      sidx = 0; slots_done = 1'b0; resp = rv; sent = '0;
      post_ticks = 0; spu_ticks = 0; overlap = 0; dones = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
      for (int cyc = 0; cyc < 2000; cyc++) begin
         @(negedge clk);
         if (cyc == 0) cmd_valid = 1'b0;
         if (cyc == 4) begin
            // stray command while busy (R5)
            cmd_valid = 1'b1; cmd_op = 2'd2; cmd_data = ~data;
         end
         if (cyc == 5) cmd_valid = 1'b0;
         if (cyc == 6 && mid_arm >= 0) begin
            arm_valid = 1'b1; arm_ms = 8'(mid_arm);
         end
         if (cyc == 7) arm_valid = 1'b0;
         #1;
         if (busy && slots_done && us_tick) post_ticks++;
         if (spu_on && us_tick) spu_ticks++;
         if (spu_on && slot_req) overlap++;
         if (done) begin
            dones++;
            check("R5 busy low with done", int'(busy), 0);
            break;
         end
      end
      @(negedge clk); #1;
      if (done) dones++;
      check("R5 single done pulse", dones, 1);
      check("R12 pullup overlaps slot", overlap, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(done), 0);
      check("R1 slot_req", int'(slot_req), 0);
      check("R1 spu_on", int'(spu_on), 0);
      check("R1 result", int'(result), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 / R4: write sweep, result untouched
      for (int v = 0; v < 256; v++) begin
         run_byte(2'd0, 8'(v), ~8'(v), -1);
         check("R2 write bits lsb first", int'(sent), v);
         check("R4 write keeps result", int'(result), int'(exp_res));
         check("R8 no hold without arm", post_ticks, 0);
      end

      // R3: read sweep
      for (int v = 0; v < 256; v++) begin
         run_byte(2'd1, 8'h00, 8'(v), -1);
         check("R3 read drives ones", int'(sent), 255);
         check("R3 read result", int'(result), v);
         exp_res = 8'(v);
      end

      // R2 / R4: touch sweep, op 3 on odd values
      for (int v = 0; v < 256; v++) begin
         run_byte((v % 2 == 1) ? 2'd3 : 2'd2, 8'(v), 8'(v) ^ 8'hA5, -1);
         check("R2 touch bits lsb first", int'(sent), v);
         check("R4 touch result", int'(result), v ^ 8'hA5);
         exp_res = 8'(v) ^ 8'hA5;
      end

      // R6 / R8: enabled pullup of 1..3 ms, then one-shot
      pullup_en = 1'b1;
      for (int ms = 1; ms <= 3; ms++) begin
         arm(ms);
         run_byte(2'd0, 8'h3C, 8'h00, -1);
         check("R6 hold ticks", post_ticks, ms * TPM);
         check("R6 pullup ticks", spu_ticks, ms * TPM);
         check("R6 write keeps result", int'(result), int'(exp_res));
         run_byte(2'd0, 8'h3C, 8'h00, -1);
         check("R8 consumed hold", post_ticks, 0);
         check("R8 consumed pullup", spu_ticks, 0);
      end

      // R7: armed but pullup disabled
      pullup_en = 1'b0;
      arm(2);
      run_byte(2'd2, 8'h81, 8'h7E, -1);
      check("R7 wait ticks", post_ticks, 2 * TPM);
      check("R7 no pullup", spu_ticks, 0);
      check("R7 touch result", int'(result), 8'h7E);
      exp_res = 8'h7E;

      // R9: zero cancels
      pullup_en = 1'b1;
      arm(3);
      arm(0);
      run_byte(2'd0, 8'h55, 8'h00, -1);
      check("R9 cancelled hold", post_ticks, 0);
      check("R9 cancelled pullup", spu_ticks, 0);

      // R11: read leaves request armed
      arm(1);
      run_byte(2'd1, 8'h00, 8'hC3, -1);
      check("R11 read no hold", post_ticks, 0);
      check("R11 read no pullup", spu_ticks, 0);
      check("R11 read result", int'(result), 8'hC3);
      exp_res = 8'hC3;
      run_byte(2'd2, 8'h0F, 8'h11, -1);
      check("R11 request survives read", spu_ticks, 1 * TPM);
      check("R11 touch result", int'(result), 8'h11);
      exp_res = 8'h11;

      // R10: arm during a byte applies to the next one
      run_byte(2'd0, 8'hF0, 8'h00, 2);
      check("R10 in-flight byte no hold", post_ticks, 0);
      check("R10 in-flight byte no pullup", spu_ticks, 0);
      run_byte(2'd0, 8'hF0, 8'h00, -1);
      check("R10 next byte pullup", spu_ticks, 2 * TPM);
      check("R10 next byte sent", int'(sent), 8'hF0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule